// File: doc/BRIEF.md
# Superscalar Fetch-Group Issue Stage

This block sits between a decoded instruction stream and a set of reservation stations in a timing model of an out-of-order core. Each record in the stream carries a class, a program counter, a branch flag with its resolved direction, and a count of extra cycles the instruction needs at issue. On every step the block forms a fetch group from the head of the stream, compares it with the free-slot count each reservation-station class reports, and releases the longest in-order prefix that fits. Exactly one group, possibly empty, leaves per step on a valid/ready issue port.

A group ends at its first branch. Records that do not fit are held in a pending group, and nothing new is fetched until that group has drained. When the released part needs extra issue cycles, empty groups go out first. A table of two-bit counters predicts each branch as it issues. A wrong guess inserts a fixed number of empty groups after the branch's group. A parameter replaces the table with perfect prediction. A counter reports how many groups have left since reset.

Top module: `fgroup_issue`

## Requirements
- R1: A fetch takes the valid prefix of the input window (slot j in bits j*field-width upward), at most ISSUE_W records, and ends after the first record whose branch flag is set. `trc_pop` reports the number of records taken on the step that fetches them and is 0 on every other step.
- R2: The issued records form an in-order prefix of the current group. A record of class c (a free count in `rs_free` bits c*FREE_W upward) issues only if fewer earlier records of class c in the same group have issued than that count. The first record that does not fit stops issue for itself and for every record after it. `iss_mask` bit j marks slot j as issued, and the set bits always form a prefix.
- R3: Records held back stay pending in order. While any are pending, `trc_pop` stays 0, and the pending records are the next ones offered for issue.
- R4: If the issued prefix has a largest extra-issue count N > 0, the block emits N empty groups, starting on that step, and then emits that prefix with its original slots and program counters.
- R5: After the first clock following reset, `iss_valid` stays high and one group leaves on each step with `iss_ready` high. An empty group has `iss_mask` equal to 0.
- R6: The predictor holds one two-bit counter per entry, indexed by the low log2(BP_ENTRIES) bits of the branch's program counter, so addresses that agree in those bits share an entry. Counters reset to 01 (weakly not taken), predict taken when the upper bit is 1, and saturate at 00 and 11 as they are updated with the resolved direction.
- R7: When a branch issues with a predicted direction that differs from its resolved direction, MISS_PEN empty groups follow the group that carries the branch (after any extra-issue bubbles and that group) before the next issue decision.
- R8: With PERFECT_BP set, a branch never causes penalty groups, and the next records issue on the following step.
- R9: On a step with `iss_ready` low, no state changes: `trc_pop` is 0, `cyc_cnt` holds, and the group on offer is still offered once ready returns.
- R10: `cyc_cnt` equals the number of steps on which a group left since reset.
- R11: During reset `iss_valid` is 0, `iss_mask` is 0 and `cyc_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_vld | input | ISSUE_W | Per-slot record present in the input window |
| trc_cls | input | ISSUE_W*CLS_W | Per-slot instruction class |
| trc_br | input | ISSUE_W | Per-slot branch flag |
| trc_tkn | input | ISSUE_W | Per-slot resolved branch direction |
| trc_pc | input | ISSUE_W*PC_W | Per-slot program counter |
| trc_xtra | input | ISSUE_W*XTRA_W | Per-slot extra issue cycles |
| trc_pop | output | PW | Records consumed from the window this step |
| rs_free | input | NCLS*FREE_W | Free reservation-station slots per class |
| iss_valid | output | 1 | Issue port carries a group |
| iss_ready | input | 1 | Consumer accepts the group this step |
| iss_mask | output | ISSUE_W | Per-slot issued flags (prefix) |
| iss_cls | output | ISSUE_W*CLS_W | Class of each issued slot |
| iss_pc | output | ISSUE_W*PC_W | Program counter of each issued slot |
| cyc_cnt | output | CYC_W | Groups emitted since reset |

## Verification
The hardest state to reach from the ports is a partly issued group whose released prefix needs extra issue cycles while a remainder is still pending. Reaching it takes a class whose free count is smaller than the number of records of that class in one fetch window, plus a multi-cycle record in the same window. The stimulus starts from a trace with exactly that mix. It then uses a second branch whose address aliases the first branch's predictor entry. This shows that the counter was trained by the earlier mispredict, and that a later opposite outcome costs the full penalty again. Narrowed free counts on chosen steps make a branch wait in the pending group, so its prediction happens a step after its fetch.

// File: rtl/fgi_pkg.sv
package fgi_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'b01;

    typedef enum logic [1:0] {
        STEP_EXTRA,
        STEP_HELD,
        STEP_PEN,
        STEP_DECIDE
    } step_e;

    function automatic ctr2_t ctr_upd(ctr2_t c, logic tkn);
        ctr2_t r;
        r = c;
        if (tkn && c != 2'b11) r = c + 2'b01;
        if (!tkn && c != 2'b00) r = c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/brpred_tbl.sv
module brpred_tbl
    import fgi_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             pred_tkn,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_tkn
);

    ctr2_t tbl_q [ENTRIES];
    ctr2_t tbl_d [ENTRIES];

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) tbl_d[upd_idx] = ctr_upd(tbl_q[upd_idx], upd_tkn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_INIT;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign pred_tkn = tbl_q[rd_idx][1];

    // R6: a saturated counter stays saturated under a confirming outcome
    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_tkn && tbl_q[upd_idx] == 2'b11) |=> (tbl_q[$past(upd_idx)] == 2'b11));

endmodule

// File: rtl/fetch_cut.sv
module fetch_cut #(
    parameter int W = 4,
    localparam int PW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vld,
    input  logic [W-1:0]  br,
    output logic [W-1:0]  grp_mask,
    output logic [PW-1:0] grp_cnt
);

    logic open;

    always_comb begin
        grp_mask = '0;
        grp_cnt  = '0;
        open     = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (open && vld[i]) begin
                grp_mask[i] = 1'b1;
                grp_cnt     = PW'(i + 1);
                if (br[i]) open = 1'b0;
            end else begin
                open = 1'b0;
            end
        end
    end

endmodule

// File: rtl/grp_pick.sv
module grp_pick #(
    parameter int W     = 4,
    parameter int NCLS  = 4,
    parameter int FW    = 3,
    localparam int CLS_W = $clog2(NCLS),
    localparam int PW    = $clog2(W + 1)
) (
    input  logic [W-1:0]       grp_mask,
    input  logic [W*CLS_W-1:0] grp_cls,
    input  logic [NCLS*FW-1:0] free,
    output logic [PW-1:0]      iss_cnt
);

    logic [FW:0] used [NCLS];
    logic        ok;
    int          ci;

    always_comb begin
        iss_cnt = '0;
        ok      = 1'b1;
        ci      = 0;
        for (int c = 0; c < NCLS; c++) used[c] = '0;
        for (int i = 0; i < W; i++) begin
            if (ok && grp_mask[i]) begin
                ci = int'(grp_cls[i*CLS_W +: CLS_W]);
                if (ci < NCLS && used[ci] < {1'b0, free[ci*FW +: FW]}) begin
                    used[ci] = used[ci] + (FW+1)'(1);
                    iss_cnt  = PW'(i + 1);
                end else begin
                    ok = 1'b0;
                end
            end else begin
                ok = 1'b0;
            end
        end
    end

endmodule

// File: rtl/fgroup_issue.sv
module fgroup_issue
    import fgi_pkg::*;
#(
    parameter int ISSUE_W    = 4,
    parameter int NCLS       = 4,
    parameter int FREE_W     = 3,
    parameter int XTRA_W     = 2,
    parameter int PC_W       = 8,
    parameter int BP_ENTRIES = 16,
    parameter int MISS_PEN   = 3,
    parameter bit PERFECT_BP = 1'b0,
    parameter int CYC_W      = 32,
    localparam int CLS_W = $clog2(NCLS),
    localparam int PW    = $clog2(ISSUE_W + 1),
    localparam int IDX_W = $clog2(BP_ENTRIES),
    localparam int PENW  = (MISS_PEN < 1) ? 1 : $clog2(MISS_PEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ISSUE_W-1:0]       trc_vld,
    input  logic [ISSUE_W*CLS_W-1:0] trc_cls,
    input  logic [ISSUE_W-1:0]       trc_br,
    input  logic [ISSUE_W-1:0]       trc_tkn,
    input  logic [ISSUE_W*PC_W-1:0]  trc_pc,
    input  logic [ISSUE_W*XTRA_W-1:0] trc_xtra,
    output logic [PW-1:0]            trc_pop,
    input  logic [NCLS*FREE_W-1:0]   rs_free,
    output logic                     iss_valid,
    input  logic                     iss_ready,
    output logic [ISSUE_W-1:0]       iss_mask,
    output logic [ISSUE_W*CLS_W-1:0] iss_cls,
    output logic [ISSUE_W*PC_W-1:0]  iss_pc,
    output logic [CYC_W-1:0]         cyc_cnt
);

    localparam int W = ISSUE_W;

    typedef struct packed {
        logic                  run;
        logic [W-1:0]          pmask;
        logic [W*CLS_W-1:0]    pcls;
        logic [W*PC_W-1:0]     ppc;
        logic [W-1:0]          pbr;
        logic [W-1:0]          ptkn;
        logic [W*XTRA_W-1:0]   pxtra;
        logic                  held;
        logic [W-1:0]          hmask;
        logic [W*CLS_W-1:0]    hcls;
        logic [W*PC_W-1:0]     hpc;
        logic [XTRA_W-1:0]     xcnt;
        logic [PENW-1:0]       pen;
        logic [CYC_W-1:0]      cyc;
    } st_t;

    st_t q, d;

    logic [W-1:0]        cut_mask;
    logic [PW-1:0]       cut_cnt;
    logic                fetch;
    logic [W-1:0]        src_mask, src_br, src_tkn;
    logic [W*CLS_W-1:0]  src_cls;
    logic [W*PC_W-1:0]   src_pc;
    logic [W*XTRA_W-1:0] src_xtra;
    logic [PW-1:0]       k;
    logic [W-1:0]        imask;
    logic [XTRA_W-1:0]   xmax;
    logic                br_hit, br_tkn, pred_tkn, upd_en, step;
    logic [IDX_W-1:0]    br_idx;
    step_e               kind;

    fetch_cut #(.W(W)) u_cut (
        .vld      (trc_vld),
        .br       (trc_br),
        .grp_mask (cut_mask),
        .grp_cnt  (cut_cnt)
    );

    assign fetch    = (q.pmask == '0);
    assign src_mask = fetch ? cut_mask : q.pmask;
    assign src_cls  = fetch ? trc_cls  : q.pcls;
    assign src_pc   = fetch ? trc_pc   : q.ppc;
    assign src_br   = fetch ? trc_br   : q.pbr;
    assign src_tkn  = fetch ? trc_tkn  : q.ptkn;
    assign src_xtra = fetch ? trc_xtra : q.pxtra;

    grp_pick #(.W(W), .NCLS(NCLS), .FW(FREE_W)) u_pick (
        .grp_mask (src_mask),
        .grp_cls  (src_cls),
        .free     (rs_free),
        .iss_cnt  (k)
    );

    always_comb begin
        imask  = '0;
        xmax   = '0;
        br_hit = 1'b0;
        br_tkn = 1'b0;
        br_idx = '0;
        for (int i = 0; i < W; i++) begin
            imask[i] = (PW'(i) < k);
            if (imask[i]) begin
                if (src_xtra[i*XTRA_W +: XTRA_W] > xmax) xmax = src_xtra[i*XTRA_W +: XTRA_W];
                if (src_br[i]) begin
                    br_hit = 1'b1;
                    br_tkn = src_tkn[i];
                    br_idx = src_pc[i*PC_W +: IDX_W];
                end
            end
        end
    end

    brpred_tbl #(.ENTRIES(BP_ENTRIES)) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (br_idx),
        .pred_tkn (pred_tkn),
        .upd_en   (upd_en),
        .upd_idx  (br_idx),
        .upd_tkn  (br_tkn)
    );

    assign step = q.run && iss_ready;

    always_comb begin
        if (q.xcnt != '0)     kind = STEP_EXTRA;
        else if (q.held)      kind = STEP_HELD;
        else if (q.pen != '0) kind = STEP_PEN;
        else                  kind = STEP_DECIDE;
    end

    always_comb begin
        d        = q;
        d.run    = 1'b1;
        iss_mask = '0;
        iss_cls  = '0;
        iss_pc   = '0;
        trc_pop  = '0;
        upd_en   = 1'b0;
        case (kind)
            STEP_EXTRA: begin
                if (step) d.xcnt = q.xcnt - 1'b1;
            end
            STEP_HELD: begin
                iss_mask = q.hmask;
                iss_cls  = q.hcls;
                iss_pc   = q.hpc;
                if (step) d.held = 1'b0;
            end
            STEP_PEN: begin
                if (step) d.pen = q.pen - 1'b1;
            end
            default: begin
                if (k != '0 && xmax == '0) begin
                    iss_mask = imask;
                    iss_cls  = src_cls;
                    iss_pc   = src_pc;
                end
                if (step) begin
                    trc_pop = fetch ? cut_cnt : '0;
                    d.pmask = src_mask >> k;
                    d.pcls  = src_cls  >> (int'(k) * CLS_W);
                    d.ppc   = src_pc   >> (int'(k) * PC_W);
                    d.pbr   = src_br   >> k;
                    d.ptkn  = src_tkn  >> k;
                    d.pxtra = src_xtra >> (int'(k) * XTRA_W);
                    if (k != '0 && xmax != '0) begin
                        d.held  = 1'b1;
                        d.hmask = imask;
                        d.hcls  = src_cls;
                        d.hpc   = src_pc;
                        d.xcnt  = xmax - 1'b1;
                    end
                    if (br_hit) begin
                        upd_en = 1'b1;
                        if (!PERFECT_BP && pred_tkn != br_tkn) d.pen = PENW'(MISS_PEN);
                    end
                end
            end
        endcase
        if (!q.run) iss_mask = '0;
        if (step) d.cyc = q.cyc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign iss_valid = q.run;
    assign cyc_cnt   = q.cyc;

    // R2: issued slots always form a prefix
    p_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((iss_mask & (iss_mask + 1'b1)) == '0));

    // R3: no fetch while records are pending
    p_pend_nofetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pmask != '0) |-> (trc_pop == '0));

    // R4: extra-issue countdown emits only empty groups
    p_extra_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xcnt != '0) |-> (iss_mask == '0));

    // R7: penalty window emits only empty groups
    p_pen_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pen != '0 && q.xcnt == '0 && !q.held) |-> (iss_mask == '0));

    // R9: nothing is consumed without a step
    p_pop_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_valid && iss_ready) |-> (trc_pop == '0));

    // R9: counter holds while stalled
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> $stable(cyc_cnt));

    // R10: counter advances by one per emitted group
    p_cyc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));

endmodule

// File: tb/test_fgroup_issue.sv
module test_fgroup_issue;

    localparam int CLK_P = 10;
    localparam int NTR   = 14;

    typedef struct packed {
        logic [11:0] free;
        logic [3:0]  mask;
        logic [2:0]  pop;
        logic [7:0]  pc0;
    } vec_t;

    // per step: free counts, expected mask, expected pop, expected pc of slot 0
    localparam vec_t VEC [18] = '{
        '{12'h492, 4'hF, 3'd4, 8'd0},   // R1 R2 full group
        '{12'h48A, 4'h1, 3'd2, 8'd4},   // R1 cut at branch, R2 class 1 has one slot
        '{12'h482, 4'h0, 3'd0, 8'd0},   // R3 branch waits, no fetch
        '{12'h492, 4'h1, 3'd0, 8'd5},   // R6 weakly-not-taken predicts wrong
        '{12'h492, 4'h0, 3'd0, 8'd0},   // R7 penalty
        '{12'h492, 4'h0, 3'd0, 8'd0},   // R7 penalty
        '{12'h492, 4'h0, 3'd0, 8'd0},   // R7 penalty
        '{12'h492, 4'h0, 3'd4, 8'd0},   // R4 first extra bubble, R2 third class 0 held
        '{12'h492, 4'h0, 3'd0, 8'd0},   // R4 second extra bubble
        '{12'h492, 4'h7, 3'd0, 8'd6},   // R4 held group released
        '{12'h492, 4'h1, 3'd0, 8'd9},   // R3 pending remainder
        '{12'h492, 4'h3, 3'd3, 8'd10},  // R2 two of class 0
        '{12'h492, 4'h1, 3'd0, 8'd21},  // R6 aliased entry trained, correct
        '{12'h492, 4'h1, 3'd1, 8'd21},  // R7 strong taken, not taken outcome
        '{12'h492, 4'h0, 3'd0, 8'd0},
        '{12'h492, 4'h0, 3'd0, 8'd0},
        '{12'h492, 4'h0, 3'd0, 8'd0},
        '{12'h492, 4'h0, 3'd0, 8'd0}    // R5 empty window bubble
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  trc_vld, trc_br, trc_tkn;
    logic [7:0]  trc_cls, trc_xtra;
    logic [31:0] trc_pc;
    logic [2:0]  trc_pop;
    logic [11:0] rs_free;
    logic        iss_valid, iss_ready;
    logic [3:0]  iss_mask;
    logic [7:0]  iss_cls;
    logic [31:0] iss_pc;
    logic [31:0] cyc_cnt;

    logic [3:0]  pf_vld, pf_br, pf_tkn;
    logic [7:0]  pf_cls, pf_xtra;
    logic [31:0] pf_pc;
    logic [2:0]  pf_pop;
    logic        pf_valid;
    logic [3:0]  pf_mask;
    logic [7:0]  pf_icls;
    logic [31:0] pf_ipc;
    logic [31:0] pf_cyc;

    logic [7:0] tpc  [NTR];
    logic [1:0] tcls [NTR];
    logic       tbr  [NTR];
    logic       ttk  [NTR];
    logic [1:0] tx   [NTR];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int ptr   = 0;

    always #(CLK_P/2) clk = ~clk;

    fgroup_issue i_fgroup_issue (
        .clk (clk), .rst_n (rst_n),
        .trc_vld (trc_vld), .trc_cls (trc_cls), .trc_br (trc_br), .trc_tkn (trc_tkn),
        .trc_pc (trc_pc), .trc_xtra (trc_xtra), .trc_pop (trc_pop), .rs_free (rs_free),
        .iss_valid (iss_valid), .iss_ready (iss_ready), .iss_mask (iss_mask),
        .iss_cls (iss_cls), .iss_pc (iss_pc), .cyc_cnt (cyc_cnt)
    );

    fgroup_issue #(.PERFECT_BP(1'b1)) i_fgroup_issue_pf (
        .clk (clk), .rst_n (rst_n),
        .trc_vld (pf_vld), .trc_cls (pf_cls), .trc_br (pf_br), .trc_tkn (pf_tkn),
        .trc_pc (pf_pc), .trc_xtra (pf_xtra), .trc_pop (pf_pop), .rs_free (12'h492),
        .iss_valid (pf_valid), .iss_ready (1'b1), .iss_mask (pf_mask),
        .iss_cls (pf_icls), .iss_pc (pf_ipc), .cyc_cnt (pf_cyc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_win(input int p);
        trc_vld = '0; trc_cls = '0; trc_br = '0; trc_tkn = '0; trc_pc = '0; trc_xtra = '0;
        for (int j = 0; j < 4; j++) begin
            if (p + j < NTR) begin
                trc_vld[j]          = 1'b1;
                trc_cls[j*2 +: 2]   = tcls[p+j];
                trc_br[j]           = tbr[p+j];
                trc_tkn[j]          = ttk[p+j];
                trc_pc[j*8 +: 8]    = tpc[p+j];
                trc_xtra[j*2 +: 2]  = tx[p+j];
            end
        end
    endtask

    task automatic set_trace(input int i, input int pc, input int cls, input bit br, input bit tk, input int x);
        tpc[i]  = 8'(pc);
        tcls[i] = 2'(cls);
        tbr[i]  = br;
        ttk[i]  = tk;
        tx[i]   = 2'(x);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 3000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        set_trace(0, 0, 0, 0, 0, 0);
        set_trace(1, 1, 1, 0, 0, 0);
        set_trace(2, 2, 0, 0, 0, 0);
        set_trace(3, 3, 2, 0, 0, 0);
        set_trace(4, 4, 1, 0, 0, 0);
        set_trace(5, 5, 1, 1, 1, 0);
        set_trace(6, 6, 3, 0, 0, 2);
        set_trace(7, 7, 0, 0, 0, 0);
        set_trace(8, 8, 0, 0, 0, 0);
        set_trace(9, 9, 0, 0, 0, 0);
        set_trace(10, 10, 0, 0, 0, 0);
        set_trace(11, 11, 0, 0, 0, 0);
        set_trace(12, 21, 0, 1, 1, 0);
        set_trace(13, 21, 0, 1, 0, 0);

        iss_ready = 1'b1;
        rs_free   = 12'h492;
        drive_win(NTR);
        pf_vld = '0; pf_cls = '0; pf_br = '0; pf_tkn = '0; pf_pc = '0; pf_xtra = '0;

        // R11 reset state
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R11", "iss_valid in reset", 32'(iss_valid), 32'd0);
        chk("R11", "iss_mask in reset", 32'(iss_mask), 32'd0);
        chk("R11", "cyc_cnt in reset", cyc_cnt, 32'd0);
        rst_n = 1'b1;

        // table walk over the trace
        for (int s = 0; s < 18; s++) begin
            @(negedge clk);
            rs_free = VEC[s].free;
            drive_win(ptr);
            #1;
            chk("R5", $sformatf("iss_valid step %0d", s), 32'(iss_valid), 32'd1);
            chk("R2", $sformatf("iss_mask step %0d", s), 32'(iss_mask), 32'(VEC[s].mask));
            chk("R1", $sformatf("trc_pop step %0d", s), 32'(trc_pop), 32'(VEC[s].pop));
            if (VEC[s].mask != 4'h0)
                chk("R4", $sformatf("slot 0 pc step %0d", s), 32'(iss_pc[7:0]), 32'(VEC[s].pc0));
            ptr = ptr + int'(trc_pop);
        end

        // R9 stall: one record offered with ready low
        @(negedge clk);
        iss_ready = 1'b0;
        trc_vld = 4'b0001; trc_cls = '0; trc_br = '0; trc_tkn = '0; trc_xtra = '0;
        trc_pc = 32'd40;
        #1;
        chk("R10", "cyc_cnt after table", cyc_cnt, 32'd18);
        chk("R9", "pop while stalled", 32'(trc_pop), 32'd0);
        @(negedge clk);
        #1;
        chk("R9", "cyc_cnt held while stalled", cyc_cnt, 32'd18);
        chk("R9", "pop still zero", 32'(trc_pop), 32'd0);
        iss_ready = 1'b1;
        #1;
        chk("R9", "offer after stall mask", 32'(iss_mask), 32'd1);
        chk("R9", "offer after stall pc", 32'(iss_pc[7:0]), 32'd40);
        chk("R9", "offer after stall pop", 32'(trc_pop), 32'd1);
        @(negedge clk);
        drive_win(NTR);
        #1;
        chk("R10", "cyc_cnt after release", cyc_cnt, 32'd19);

        // R8 perfect prediction: taken branch then a record with no penalty gap
        pf_vld = 4'b0001; pf_br = 4'b0001; pf_tkn = 4'b0001; pf_pc = 32'd5;
        #1;
        chk("R8", "perfect branch mask", 32'(pf_mask), 32'd1);
        chk("R8", "perfect branch pop", 32'(pf_pop), 32'd1);
        @(negedge clk);
        pf_vld = 4'b0001; pf_br = '0; pf_tkn = '0; pf_pc = 32'd30;
        #1;
        chk("R8", "no penalty after branch mask", 32'(pf_mask), 32'd1);
        chk("R8", "no penalty after branch pc", 32'(pf_ipc[7:0]), 32'd30);
        @(negedge clk);
        pf_vld = '0;

        // R11 reset again
        rst_n = 1'b0;
        #1;
        chk("R11", "iss_valid after reset", 32'(iss_valid), 32'd0);
        chk("R11", "cyc_cnt after reset", cyc_cnt, 32'd0);
        chk("R11", "iss_mask after reset", 32'(iss_mask), 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule